// File: doc/BRIEF.md
# Reset-Aware Bus Release Arbiter

This block owns an external memory bus and decides, each clock, whether that bus runs a local transfer, runs a refresh cycle, or is handed to an outside master. A local master asks for single-longword or multi-beat burst transfers through a level request. The block acknowledges each completed beat and flags the final one. An interval counter raises a refresh request at a fixed period, and that refresh is served as a short refresh cycle. An outside master asks for the bus through an asynchronous request line. The line is synchronized, and the bus is granted only when no local transfer or refresh is running and no refresh is waiting. While the grant is held, the block's own drivers are switched off.

Two resets behave differently. The asynchronous power-on reset clears every register and drops every bus output and driver enable at once, even in the middle of a beat. The manual reset is a level input sampled on the clock. It changes no register content. While it is high, the beat in progress finishes and any burst is cut at that beat. No new transfer, refresh cycle or grant is started, and the refresh interval counter holds its value. A grant that is already held stays for as long as the outside request stays. If that request drops, the grant is released even while the manual reset is high. A request that first arrives during the manual reset waits until the manual reset goes low.

Top module: `busRelArb`

## Requirements
- R1: While porRstN is low, extGrant, cycActive, mstAck and busDrvEn are 0 at once, even part-way through a beat or a grant. The refresh interval counter restarts from zero, so after release the first rfshReq rise comes a full RFSH_PERIOD edges later.
- R2: After power-on reset release, rfshReq rises after RFSH_PERIOD rising clock edges and again every RFSH_PERIOD edges after that. Each rise is followed by a refresh cycle of RFSH_CYC clocks, and rfshReq stays high for RFSH_CYC+1 sampled cycles.
- R3: While manRst is high, the refresh interval counter keeps its value. Holding manRst for M edges delays the next rfshReq rise by exactly M edges.
- R4: A local request with mstBurst=0 gets one mstAck, with mstLast, BEAT_CYC cycles after the request. With mstBurst=1 it gets BURST_BEATS acks spaced BEAT_CYC cycles apart, and mstLast comes only with the final ack.
- R5: If manRst goes high during a burst, the beat in progress completes. Its ack carries mstLast, and no further acks follow.
- R6: While manRst is high, a pending local request starts no transfer (cycActive stays 0). The transfer starts on the first edge after manRst goes low.
- R7: extReq passes through two synchronizer flops. From idle, extGrant rises 3 edges after extReq rises and falls 3 edges after it drops. While granted, busDrvEn is 0 and cycActive is 0.
- R8: A request that arrives during a local transfer is granted only after the transfer ends, 2 edges after the final ack. extGrant and cycActive are never high together.
- R9: A pending refresh is served before the grant. A request raised in the cycle where rfshReq rises is granted RFSH_CYC+2 edges later, by which time rfshReq is 0.
- R10: A grant that is held when manRst rises stays high through the manual reset while extReq stays high.
- R11: If extReq drops while manRst is high, extGrant falls 3 edges later, without waiting for manRst to go low, and busDrvEn returns to 1.
- R12: A request that first arrives while manRst is high gets no grant during the manual reset. The grant rises on the first edge after manRst goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| manRst | input | 1 | Manual reset, active high, sampled on clk |
| extReq | input | 1 | Asynchronous bus request from the outside master |
| extGrant | output | 1 | Bus granted to the outside master |
| mstReq | input | 1 | Local master transfer request (level) |
| mstBurst | input | 1 | 1 selects a BURST_BEATS-beat burst, 0 a single beat |
| mstAck | output | 1 | One-cycle pulse at the end of each completed beat |
| mstLast | output | 1 | Marks the ack of the final beat |
| cycActive | output | 1 | A local transfer is in progress |
| busDrvEn | output | 1 | Enable for the block's address and control drivers |
| rfshReq | output | 1 | Refresh pending or in progress |

## Verification
Each result is due a fixed number of edges after its stimulus. The grant takes 3 edges to rise or fall from idle: two synchronizer flops plus the state register. The first ack comes BEAT_CYC edges after a local request. A grant behind a transfer comes 2 edges after the final ack, and a grant behind a refresh comes RFSH_CYC+2 edges after the request. The refresh rises at multiples of RFSH_PERIOD, shifted by the number of manual-reset edges. Inputs change on falling edges and outputs are read at the next falling edge, so the bench counts edges between stimulus and response and compares that count with the exact figure. Power-on reset effects are checked a nanosecond after the asynchronous assertion, before any clock edge.

// File: rtl/busArbPkg.sv
package busArbPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_RFSH  = 2'd2,
    ST_GRANT = 2'd3
  } arbState_t;

  // strobes from the control FSM to the counters
  typedef struct packed {
    logic loadXfer;
    logic burst;
    logic stepXfer;
    logic loadRfsh;
    logic stepRfsh;
    logic clrPend;
  } arbStrobe_t;

endpackage

// File: rtl/busArbDp.sv
module busArbDp
  import busArbPkg::*;
#(
  parameter int RFSH_PERIOD = 64,
  parameter int BEAT_CYC    = 2,
  parameter int BURST_BEATS = 4,
  parameter int RFSH_CYC    = 3
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic       manRst,
  input  logic       extReq,
  input  arbStrobe_t stb,
  output logic       reqSync,
  output logic       rfPend,
  output logic       beatEnd,
  output logic       lastBeat,
  output logic       rfEnd
);

  localparam int RW = (RFSH_PERIOD > 1) ? $clog2(RFSH_PERIOD) : 1;
  localparam int CW = (BEAT_CYC > 1) ? $clog2(BEAT_CYC) : 1;
  localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam int FW = (RFSH_CYC > 1) ? $clog2(RFSH_CYC) : 1;

  logic          syncA;
  logic [RW-1:0] rfCnt;
  logic [CW-1:0] cycCnt;
  logic [BW-1:0] beatsLeft;
  logic [FW-1:0] rCyc;

  // two-flop synchronizer on the outside request
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      syncA   <= 1'b0;
      reqSync <= 1'b0;
    end else begin
      syncA   <= extReq;
      reqSync <= syncA;
    end
  end

  // refresh interval counter, frozen during manual reset
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rfCnt  <= '0;
      rfPend <= 1'b0;
    end else begin
      if (stb.clrPend) rfPend <= 1'b0;
      if (!manRst) begin
        if (rfCnt == RW'(RFSH_PERIOD - 1)) begin
          rfCnt  <= '0;
          rfPend <= 1'b1;
        end else begin
          rfCnt <= rfCnt + 1'b1;
        end
      end
    end
  end

  // beat and burst counters
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cycCnt    <= '0;
      beatsLeft <= '0;
    end else if (stb.loadXfer) begin
      cycCnt    <= '0;
      beatsLeft <= stb.burst ? BW'(BURST_BEATS - 1) : '0;
    end else if (stb.stepXfer) begin
      if (beatEnd) begin
        cycCnt <= '0;
        if (beatsLeft != '0) beatsLeft <= beatsLeft - 1'b1;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end
  end

  // refresh cycle length counter
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          rCyc <= '0;
    else if (stb.loadRfsh) rCyc <= '0;
    else if (stb.stepRfsh) rCyc <= rCyc + 1'b1;
  end

  assign beatEnd  = (cycCnt == CW'(BEAT_CYC - 1));
  assign lastBeat = (beatsLeft == '0);
  assign rfEnd    = (rCyc == FW'(RFSH_CYC - 1));

  assert_rfsh_frozen_R3: assert property (@(posedge clk) disable iff (!porRstN)
    manRst |=> $stable(rfCnt));

  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(rfPend) |-> $past(stb.clrPend));

endmodule

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic       manRst,
  input  logic       mstReq,
  input  logic       mstBurst,
  input  logic       reqSync,
  input  logic       rfPend,
  input  logic       beatEnd,
  input  logic       lastBeat,
  input  logic       rfEnd,
  output arbStrobe_t stb,
  output logic       extGrant,
  output logic       cycActive,
  output logic       mstAck,
  output logic       mstLast
);

  arbState_t st, nxt;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) st <= ST_IDLE;
    else          st <= nxt;
  end

  always_comb begin
    nxt = st;
    stb = '0;
    unique case (st)
      ST_IDLE: begin
        if (!manRst) begin
          if (rfPend) begin
            nxt          = ST_RFSH;
            stb.loadRfsh = 1'b1;
          end else if (reqSync) begin
            nxt = ST_GRANT;
          end else if (mstReq) begin
            nxt          = ST_XFER;
            stb.loadXfer = 1'b1;
            stb.burst    = mstBurst;
          end
        end
      end
      ST_XFER: begin
        stb.stepXfer = 1'b1;
        if (beatEnd && (lastBeat || manRst)) nxt = ST_IDLE;
      end
      ST_RFSH: begin
        stb.stepRfsh = 1'b1;
        if (rfEnd) begin
          nxt         = ST_IDLE;
          stb.clrPend = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!reqSync) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign extGrant  = (st == ST_GRANT);
  assign cycActive = (st == ST_XFER);
  assign mstAck    = cycActive && beatEnd;
  assign mstLast   = mstAck && (lastBeat || manRst);

  assert_no_grant_in_mrst_R12: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(extGrant) |-> !$past(manRst));

  assert_burst_cut_R5: assert property (@(posedge clk) disable iff (!porRstN)
    (cycActive && beatEnd && manRst) |=> !cycActive);

  assert_rfsh_first_R9: assert property (@(posedge clk) disable iff (!porRstN)
    (rfPend && !extGrant && !cycActive) |=> !$rose(extGrant));

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(extGrant) |-> $past(reqSync));

endmodule

// File: rtl/busRelArb.sv
module busRelArb
  import busArbPkg::*;
#(
  parameter int RFSH_PERIOD = 64,
  parameter int BEAT_CYC    = 2,
  parameter int BURST_BEATS = 4,
  parameter int RFSH_CYC    = 3
) (
  input  logic clk,
  input  logic porRstN,
  input  logic manRst,
  input  logic extReq,
  output logic extGrant,
  input  logic mstReq,
  input  logic mstBurst,
  output logic mstAck,
  output logic mstLast,
  output logic cycActive,
  output logic busDrvEn,
  output logic rfshReq
);

  arbStrobe_t stb;
  logic reqSync, rfPend, beatEnd, lastBeat, rfEnd;

  busArbDp #(
    .RFSH_PERIOD(RFSH_PERIOD), .BEAT_CYC(BEAT_CYC),
    .BURST_BEATS(BURST_BEATS), .RFSH_CYC(RFSH_CYC)
  ) uDp (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .extReq(extReq), .stb(stb),
    .reqSync(reqSync), .rfPend(rfPend), .beatEnd(beatEnd), .lastBeat(lastBeat),
    .rfEnd(rfEnd)
  );

  busArbCtrl uCtrl (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .mstReq(mstReq),
    .mstBurst(mstBurst), .reqSync(reqSync), .rfPend(rfPend), .beatEnd(beatEnd),
    .lastBeat(lastBeat), .rfEnd(rfEnd), .stb(stb), .extGrant(extGrant),
    .cycActive(cycActive), .mstAck(mstAck), .mstLast(mstLast)
  );

  // drivers off at once in power-on reset and whenever the bus is released
  assign busDrvEn = porRstN && !extGrant;
  assign rfshReq  = rfPend;

  assert_por_quiet_R1: assert property (@(posedge clk)
    !porRstN |-> (!extGrant && !cycActive && !busDrvEn && !mstAck));

  assert_grant_drv_off_R7: assert property (@(posedge clk) disable iff (!porRstN)
    extGrant |-> (!busDrvEn && !cycActive));

endmodule

// File: tb/tb_busRelArb.sv
module tb_busRelArb;

  localparam int P  = 24;
  localparam int BC = 2;
  localparam int BB = 4;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic porRstN, manRst, extReq, mstReq, mstBurst;
  logic extGrant, mstAck, mstLast, cycActive, busDrvEn, rfshReq;

  int vecs = 0;
  int miss = 0;
  bit done = 0;

  always #5 clk = ~clk;

  busRelArb #(.RFSH_PERIOD(P), .BEAT_CYC(BC), .BURST_BEATS(BB), .RFSH_CYC(RC)) dut (
    .clk(clk), .porRstN(porRstN), .manRst(manRst), .extReq(extReq),
    .extGrant(extGrant), .mstReq(mstReq), .mstBurst(mstBurst), .mstAck(mstAck),
    .mstLast(mstLast), .cycActive(cycActive), .busDrvEn(busDrvEn), .rfshReq(rfshReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic por;
    porRstN = 1'b0; manRst = 1'b0; extReq = 1'b0; mstReq = 1'b0; mstBurst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    porRstN = 1'b1;
  endtask

  // edges until extGrant reaches lvl
  task automatic waitGrant(input logic lvl, output int n);
    n = 0;
    do begin tick(); n++; end while (extGrant != lvl && n < 60);
  endtask

  // edges until rfshReq rises, counted into n
  task automatic waitRfsh(inout int n);
    int k = 0;
    do begin tick(); n++; k++; end while (!rfshReq && k < 200);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miss++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    int n, acks, firstAck, lastAt, h;
    bit bad;

    // reset state, R1
    porRstN = 1'b0; manRst = 1'b0; extReq = 1'b0; mstReq = 1'b0; mstBurst = 1'b0;
    @(negedge clk);
    check("R1", "busDrvEn in reset", busDrvEn, 0);
    check("R1", "grant/cyc/rfsh in reset", {extGrant, cycActive, rfshReq}, 0);
    @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    check("R1", "busDrvEn after release", busDrvEn, 1);

    // R2 refresh period and length
    por();
    n = 0;
    waitRfsh(n);
    check("R2", "first refresh edge", n, P);
    h = 1;
    while (rfshReq && h < 50) begin tick(); n++; if (rfshReq) h++; end
    check("R2", "refresh high samples", h, RC + 1);
    waitRfsh(n);
    check("R2", "second refresh edge", n, 2 * P);

    // R3 manual reset freezes the interval counter
    por();
    n = 0;
    waitRfsh(n);
    while (rfshReq) begin tick(); n++; end
    manRst = 1'b1;
    repeat (7) begin tick(); n++; end
    manRst = 1'b0;
    waitRfsh(n);
    check("R3", "refresh edge after 7 frozen", n, 2 * P + 7);

    // R4 single transfer
    por();
    mstReq = 1'b1; mstBurst = 1'b0;
    acks = 0; firstAck = 0; lastAt = 0; n = 0;
    while (lastAt == 0 && n < 40) begin
      tick(); n++;
      if (mstAck) begin acks++; if (acks == 1) firstAck = n; end
      if (mstAck && mstLast) begin lastAt = n; mstReq = 1'b0; end
    end
    check("R4", "single ack count", acks, 1);
    check("R4", "single ack edge", firstAck, BC);
    tick();
    check("R4", "cycActive after single", cycActive, 0);

    // R4 full burst
    por();
    mstReq = 1'b1; mstBurst = 1'b1;
    acks = 0; lastAt = 0; n = 0; bad = 0;
    while (lastAt == 0 && n < 40) begin
      tick(); n++;
      if (mstAck) acks++;
      if (mstAck && mstLast) begin lastAt = n; mstReq = 1'b0; end
      else if (mstLast) bad = 1;
    end
    check("R4", "burst ack count", acks, BB);
    check("R4", "burst last edge", lastAt, BB * BC);
    check("R4", "stray mstLast", bad, 0);

    // R5 burst cut by manual reset raised in beat 2
    por();
    mstReq = 1'b1; mstBurst = 1'b1;
    acks = 0; lastAt = 0; n = 0;
    while (lastAt == 0 && n < 40) begin
      tick(); n++;
      if (acks == 1 && !mstAck && !manRst) manRst = 1'b1;
      if (mstAck) acks++;
      if (mstAck && mstLast) begin lastAt = n; mstReq = 1'b0; end
    end
    check("R5", "acks with cut", acks, 2);
    check("R5", "cut last edge", lastAt, 2 * BC);
    acks = 0;
    repeat (6) begin tick(); if (mstAck) acks++; end
    check("R5", "acks after cut", acks, 0);

    // R6 no new transfer in manual reset (manRst still high)
    mstReq = 1'b1; mstBurst = 1'b0; bad = 0;
    repeat (6) begin tick(); if (cycActive) bad = 1; end
    check("R6", "cycActive during manRst", bad, 0);
    manRst = 1'b0;
    tick();
    check("R6", "cycActive after release", cycActive, 1);
    while (!mstLast) tick();
    mstReq = 1'b0;

    // R7 grant latency and driver release
    por();
    extReq = 1'b1;
    waitGrant(1'b1, n);
    check("R7", "grant rise edges", n, 3);
    check("R7", "busDrvEn while granted", busDrvEn, 0);
    check("R7", "cycActive while granted", cycActive, 0);
    extReq = 1'b0;
    waitGrant(1'b0, n);
    check("R7", "grant fall edges", n, 3);
    check("R7", "busDrvEn after release", busDrvEn, 1);

    // R8 grant waits for the local burst
    por();
    mstReq = 1'b1; mstBurst = 1'b1;
    n = 0; lastAt = 0; bad = 0;
    while (!extGrant && n < 60) begin
      tick(); n++;
      if (mstAck) extReq = 1'b1;
      if (mstAck && mstLast) begin lastAt = n; mstReq = 1'b0; end
      if (extGrant && cycActive) bad = 1;
    end
    check("R8", "grant/cyc overlap", bad, 0);
    check("R8", "grant edges after last ack", n - lastAt, 2);
    extReq = 1'b0;
    waitGrant(1'b0, n);

    // R9 pending refresh beats the grant
    por();
    n = 0;
    waitRfsh(n);
    extReq = 1'b1;
    waitGrant(1'b1, n);
    check("R9", "grant edges behind refresh", n, RC + 2);
    check("R9", "rfshReq at grant", rfshReq, 0);
    extReq = 1'b0;
    waitGrant(1'b0, n);

    // R10 grant held through manual reset
    por();
    extReq = 1'b1;
    waitGrant(1'b1, n);
    manRst = 1'b1; bad = 0;
    repeat (8) begin tick(); if (!extGrant) bad = 1; end
    check("R10", "grant dropped in manRst", bad, 0);
    manRst = 1'b0;
    tick();
    check("R10", "grant after manRst", extGrant, 1);
    extReq = 1'b0;
    waitGrant(1'b0, n);

    // R11 request dropped during manual reset
    por();
    extReq = 1'b1;
    waitGrant(1'b1, n);
    manRst = 1'b1;
    tick(); tick();
    extReq = 1'b0;
    waitGrant(1'b0, n);
    check("R11", "release edges in manRst", n, 3);
    check("R11", "busDrvEn back", busDrvEn, 1);
    manRst = 1'b0;

    // R12 request first seen during manual reset
    por();
    manRst = 1'b1;
    tick(); tick();
    extReq = 1'b1; bad = 0;
    repeat (8) begin tick(); if (extGrant) bad = 1; end
    check("R12", "grant during manRst", bad, 0);
    manRst = 1'b0;
    tick();
    check("R12", "grant one edge after release", extGrant, 1);
    extReq = 1'b0;
    waitGrant(1'b0, n);

    // R1 power-on reset mid-burst
    por();
    mstReq = 1'b1; mstBurst = 1'b1;
    n = 0;
    while (!mstAck && n < 20) begin tick(); n++; end
    #2 porRstN = 1'b0;
    #1;
    check("R1", "outputs mid-burst", {cycActive, mstAck, busDrvEn}, 0);
    mstReq = 1'b0;
    @(negedge clk);
    porRstN = 1'b1;
    n = 0;
    waitRfsh(n);
    check("R1", "refresh counter cleared", n, P);

    // R1 power-on reset during a grant
    por();
    extReq = 1'b1;
    waitGrant(1'b1, n);
    #2 porRstN = 1'b0;
    #1;
    check("R1", "grant and drivers in reset", {extGrant, busDrvEn}, 0);
    extReq = 1'b0;
    @(negedge clk);
    porRstN = 1'b1;
    tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule